// File: doc/BRIEF.md
# Duration-Coded Symbol Transmit Sequencer

This block serializes host-supplied bytes onto a two-level line. Each bit becomes one symbol. A symbol starts with a transition of the line, and then the line holds its new level for one unit symbol time (UST) for a 1 or two UST for a 0. A free-running tick input marks UST boundaries. The host fills the transmit byte and the request bits and raises `byte_ready`. The block copies them into an internal holding register and pulses `host_irq`, and the host may then present the next byte while the current one is still on the line.

Each byte can optionally drop its most significant zero bits. It can also carry a trailing delimiter: end-of-frame (a long dwell) or end-of-packet (a longer dwell). A 16-bit CRC is accumulated over the symbol dwell lengths. After the end-of-packet dwell, the CRC goes out as sixteen one-UST line levels. These levels are expressed relative to the level used by the end-of-packet symbol. A final pulse then hands control to timestamp delivery. Dropping the transmit request aborts at once and returns the line low.

Top module: `dsym_tx_seq`

## Requirements
- R1: Out of reset and while idle, `line_out`, `host_irq` and `crc_done` are low.
- R2: Bits of each byte go out least significant first. Every data symbol begins with a line transition at a tick. A 1 then holds for one UST and a 0 holds for two UST.
- R3: With `req_lzs` high, only bits up to and including the highest set bit are sent. A zero byte with `req_lzs` high sends no data symbols, only its delimiter.
- R4: `req_delim` 2'b01 appends an end-of-frame symbol, which is a transition followed by a 3-UST dwell. 2'b10 appends an end-of-packet symbol, which is a transition followed by a 4-UST dwell. 2'b00 and the refused code 2'b11 append nothing.
- R5: Copying a byte and its request bits into the holding register pulses `host_irq` for one cycle. The held byte's first symbol starts at the very tick the previous symbol ends, with no gap.
- R6: The CRC uses polynomial 0x1021 and is preset to 0xFFFF when a packet starts. Each 1-UST data dwell shifts in a 1 and each 2-UST data dwell shifts in a 0. Delimiters do not feed it.
- R7: After the end-of-packet dwell, 16 CRC symbols of one UST each follow, most significant bit first. A 1 bit is sent as the end-of-packet line level and a 0 bit as the opposite level.
- R8: When the last CRC symbol ends, `crc_done` and `host_irq` pulse together for one cycle. The line then holds until `req_tx` falls.
- R9: Clearing `req_tx` in any non-idle state returns to idle at the next clock edge with `line_out` low. It discards any held byte and produces no further interrupt or `crc_done`.
- R10: While `req_tx` is high, `line_out` changes only at a clock edge where `sym_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_tick | input | 1 | One-cycle pulse marking each unit symbol time |
| req_tx | input | 1 | Transmit request; low forces idle |
| req_lzs | input | 1 | Suppress high-order zero bits of the byte |
| req_delim | input | 2 | Delimiter select: 00 none, 01 end-of-frame, 10 end-of-packet, 11 none |
| byte_ready | input | 1 | Host byte and request bits are valid for copying |
| tx_byte | input | 8 | Host transmit byte |
| host_irq | output | 1 | One-cycle interrupt on byte copy and on CRC completion |
| line_out | output | 1 | Two-level line output, low when idle |
| crc_done | output | 1 | One-cycle pulse after the last CRC symbol |

## Verification
The bench keeps the default parameters: 8-bit bytes, a 16-bit CRC, and 3- and 4-UST delimiters. The tick arrives every fourth clock. This keeps a three-byte packet under a few hundred cycles, so packets whose bytes cover all 256 values can be swept. The sweep alternates the zero-suppress setting and cycles through every delimiter code, including the refused one. The line is sampled once per UST and decoded back into dwell lengths and CRC levels, which are compared against a dwell list and a CRC computed arithmetically in the bench. A delimiter-only packet, an abort in mid-byte with a byte pending, and a packet after the abort cover the remaining corners.

// File: rtl/dsym_pkg.sv
package dsym_pkg;
  typedef enum logic [1:0] {
    DL_NONE = 2'b00,
    DL_EOF  = 2'b01,
    DL_EOP  = 2'b10,
    DL_RSVD = 2'b11
  } delim_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_CRC,
    ST_HAND
  } state_e;
endpackage

// File: rtl/dsym_crc.sv
module dsym_crc #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic feed_en,
  input  logic feed_bit,
  input  logic shift_en,
  output logic msb_o
);
  logic [W-1:0] crc_q, crc_n;
  logic         fb;

  always_comb begin
    fb    = crc_q[W-1] ^ feed_bit;
    crc_n = crc_q;
    if (preset)        crc_n = INIT;
    else if (feed_en)  crc_n = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (shift_en) crc_n = {crc_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_n;
  end

  assign msb_o = crc_q[W-1];

  // R6
  crc_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (crc_q == INIT));
endmodule

// File: rtl/dsym_hold.sv
module dsym_hold import dsym_pkg::*; #(
  parameter int BYTE_W = 8,
  parameter int NB_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              load_lzs,
  input  delim_e            load_delim,
  input  logic              take,
  output logic              full_o,
  output logic              fire_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [NB_W-1:0]   nbits_o,
  output delim_e            delim_o
);
  logic              full_q;
  logic [BYTE_W-1:0] byte_q;
  logic [NB_W-1:0]   nbits_q;
  delim_e            delim_q;

  function automatic logic [NB_W-1:0] live_bits(logic [BYTE_W-1:0] b, logic lzs);
    int c;
    c = lzs ? 0 : BYTE_W;
    if (lzs) begin
      for (int i = 0; i < BYTE_W; i++) if (b[i]) c = i + 1;
    end
    return NB_W'(c);
  endfunction

  assign fire_o = load_en && !full_q && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      byte_q  <= '0;
      nbits_q <= '0;
      delim_q <= DL_NONE;
    end else if (flush) begin
      full_q <= 1'b0;
    end else if (fire_o) begin
      full_q  <= 1'b1;
      byte_q  <= load_byte;
      nbits_q <= live_bits(load_byte, load_lzs);
      delim_q <= (load_delim == DL_RSVD) ? DL_NONE : load_delim;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign full_o  = full_q;
  assign byte_o  = byte_q;
  assign nbits_o = nbits_q;
  assign delim_o = delim_q;

  // R5
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take && !flush) |=> full_q);
endmodule

// File: rtl/dsym_tx_seq.sv
module dsym_tx_seq import dsym_pkg::*; #(
  parameter int                BYTE_W   = 8,
  parameter int                CRC_W    = 16,
  parameter logic [CRC_W-1:0]  CRC_POLY = 16'h1021,
  parameter logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF,
  parameter int                EOF_UST  = 3,
  parameter int                EOP_UST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_tick,
  input  logic              req_tx,
  input  logic              req_lzs,
  input  logic [1:0]        req_delim,
  input  logic              byte_ready,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              host_irq,
  output logic              line_out,
  output logic              crc_done
);
  localparam int CNT_W = $clog2(EOP_UST);
  localparam int NB_W  = $clog2(BYTE_W + 1);
  localparam int CL_W  = $clog2(CRC_W + 1);

  state_e            st_q, st_n;
  logic              line_q, line_n, eop_q, eop_n, done_q, done_n, irq_q, irq_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n, eff_sh;
  logic [NB_W-1:0]   n_q, n_n, eff_n;
  delim_e            dl_q, dl_n, eff_dl;
  logic [CL_W-1:0]   crcl_q, crcl_n;

  logic              crc_preset, crc_feed, crc_shift, crc_msb;
  logic              hold_full, hold_fire, hold_take, flush, take_hold, load_en;
  logic [BYTE_W-1:0] hold_byte;
  logic [NB_W-1:0]   hold_n;
  delim_e            hold_dl;

  assign load_en = (st_q == ST_SEND) && req_tx && byte_ready;

  dsym_hold #(.BYTE_W(BYTE_W), .NB_W(NB_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load_en(load_en),
    .load_byte(tx_byte), .load_lzs(req_lzs), .load_delim(delim_e'(req_delim)),
    .take(hold_take), .full_o(hold_full), .fire_o(hold_fire),
    .byte_o(hold_byte), .nbits_o(hold_n), .delim_o(hold_dl)
  );

  dsym_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
    .clk(clk), .rst_n(rst_n), .preset(crc_preset), .feed_en(crc_feed),
    .feed_bit(eff_sh[0]), .shift_en(crc_shift), .msb_o(crc_msb)
  );

  // Current byte exhausted: the held byte takes over at the same boundary.
  assign take_hold = hold_full && (n_q == '0) && (dl_q == DL_NONE);
  assign eff_sh    = take_hold ? hold_byte : sh_q;
  assign eff_n     = take_hold ? hold_n    : n_q;
  assign eff_dl    = take_hold ? hold_dl   : dl_q;

  always_comb begin
    st_n = st_q;  line_n = line_q;  cnt_n = cnt_q;  sh_n = sh_q;
    n_n = n_q;  dl_n = dl_q;  eop_n = eop_q;  crcl_n = crcl_q;
    done_n = 1'b0;  crc_preset = 1'b0;  crc_feed = 1'b0;  crc_shift = 1'b0;
    hold_take = 1'b0;  flush = 1'b0;
    case (st_q)
      ST_IDLE: begin
        line_n = 1'b0;
        if (req_tx) begin
          st_n = ST_SEND;  crc_preset = 1'b1;
          cnt_n = '0;  n_n = '0;  dl_n = DL_NONE;
        end
      end
      ST_SEND: begin
        if (sym_tick) begin
          if (cnt_q != '0) begin
            cnt_n = cnt_q - CNT_W'(1);
          end else begin
            hold_take = take_hold;
            if (eff_n != '0) begin
              line_n   = ~line_q;
              cnt_n    = eff_sh[0] ? CNT_W'(0) : CNT_W'(1);
              crc_feed = 1'b1;
              sh_n     = eff_sh >> 1;
              n_n      = eff_n - NB_W'(1);
              dl_n     = eff_dl;
            end else if (eff_dl != DL_NONE) begin
              line_n = ~line_q;
              n_n    = '0;
              dl_n   = DL_NONE;
              if (eff_dl == DL_EOP) begin
                cnt_n  = CNT_W'(EOP_UST - 1);
                eop_n  = ~line_q;
                crcl_n = CL_W'(CRC_W);
                st_n   = ST_CRC;
              end else begin
                cnt_n = CNT_W'(EOF_UST - 1);
              end
            end else begin
              n_n  = '0;
              dl_n = DL_NONE;
            end
          end
        end
      end
      ST_CRC: begin
        if (sym_tick) begin
          if (cnt_q != '0) begin
            cnt_n = cnt_q - CNT_W'(1);
          end else if (crcl_q != '0) begin
            line_n    = crc_msb ? eop_q : ~eop_q;
            crc_shift = 1'b1;
            crcl_n    = crcl_q - CL_W'(1);
          end else begin
            done_n = 1'b1;
            st_n   = ST_HAND;
          end
        end
      end
      default: ;
    endcase
    if (st_q != ST_IDLE && !req_tx) begin
      st_n = ST_IDLE;  line_n = 1'b0;  flush = 1'b1;  done_n = 1'b0;
      crc_feed = 1'b0;  crc_shift = 1'b0;  hold_take = 1'b0;
    end
    irq_n = hold_fire | done_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  line_q <= 1'b0;  cnt_q <= '0;  sh_q <= '0;
      n_q <= '0;  dl_q <= DL_NONE;  eop_q <= 1'b0;  crcl_q <= '0;
      done_q <= 1'b0;  irq_q <= 1'b0;
    end else begin
      st_q <= st_n;  line_q <= line_n;  cnt_q <= cnt_n;  sh_q <= sh_n;
      n_q <= n_n;  dl_q <= dl_n;  eop_q <= eop_n;  crcl_q <= crcl_n;
      done_q <= done_n;  irq_q <= irq_n;
    end
  end

  assign line_out = line_q;
  assign crc_done = done_q;
  assign host_irq = irq_q;

  // R1
  idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !line_out);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |=> !crc_done);
  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_done |-> host_irq);
  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !req_tx) |=> (!line_out && st_q == ST_IDLE));
  // R10
  line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_tick && req_tx) |=> $stable(line_out));
endmodule

// File: tb/dsym_tx_seq_tb_top.sv
module dsym_tx_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_tick = 1'b0;
  logic       req_tx = 1'b0, req_lzs = 1'b0, byte_ready = 1'b0;
  logic [1:0] req_delim = 2'b00;
  logic [7:0] tx_byte = 8'h00;
  logic       host_irq, line_out, crc_done;

  int chk_n = 0, fail_n = 0;
  int tdiv = 0;
  logic rec [0:2047];
  int nrec = 0, irq_cnt = 0, done_cnt = 0, r10_bad = 0;
  bit rec_on = 0;
  logic prev_line = 1'b0;
  logic [7:0] pb [0:2];
  logic       pl [0:2];
  logic [1:0] pd [0:2];

  always #10 clk = ~clk;

  dsym_tx_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .req_tx(req_tx),
    .req_lzs(req_lzs), .req_delim(req_delim), .byte_ready(byte_ready),
    .tx_byte(tx_byte), .host_irq(host_irq), .line_out(line_out), .crc_done(crc_done)
  );

  always @(negedge clk) begin
    if (rec_on && sym_tick && nrec < 2048) begin rec[nrec] = line_out; nrec++; end
    if (host_irq) irq_cnt++;
    if (crc_done) done_cnt++;
    if (rst_n && line_out != prev_line && !sym_tick && req_tx) r10_bad++;
    prev_line = line_out;
    tdiv = (tdiv + 1) % 4;
    sym_tick = (tdiv == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_packet(input int nb);
    int exp_d [0:63];
    int ne, n, idx, len, w, bad_i, bad_a, bad_e;
    logic [15:0] crc;
    logic lvl, eop, fb, hold_lvl;
    ne = 0; crc = 16'hFFFF; eop = 1'b0;
    for (int k = 0; k < nb; k++) begin
      if (pl[k]) begin
        n = 0;
        for (int i = 0; i < 8; i++) if (pb[k][i]) n = i + 1;
      end else n = 8;
      for (int j = 0; j < n; j++) begin
        exp_d[ne] = pb[k][j] ? 1 : 2; ne++;
        fb = crc[15] ^ pb[k][j];
        crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
      if (pd[k] == 2'b01) begin exp_d[ne] = 3; ne++; end
      if (pd[k] == 2'b10) begin exp_d[ne] = 4; ne++; end
    end
    @(negedge clk);
    nrec = 0; irq_cnt = 0; done_cnt = 0; rec_on = 1; req_tx = 1'b1;
    for (int k = 0; k < nb; k++) begin
      tx_byte = pb[k]; req_lzs = pl[k]; req_delim = pd[k]; byte_ready = 1'b1;
      w = 0;
      do begin @(negedge clk); w++; end while (!host_irq && w < 2000);
      byte_ready = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 3000) begin @(negedge clk); w++; end
    hold_lvl = line_out;
    repeat (12) @(negedge clk);
    chk(line_out == hold_lvl, "R8 line held after crc_done", int'(line_out), int'(hold_lvl));
    // decode recorded per-UST levels back into dwells (R2 R3 R4)
    idx = 0;
    while (idx < nrec && rec[idx] == 1'b0) idx++;
    bad_i = -1; bad_a = 0; bad_e = 0;
    for (int s = 0; s < ne; s++) begin
      if (idx >= nrec) begin
        if (bad_i < 0) begin bad_i = s; bad_a = 0; bad_e = exp_d[s]; end
      end else begin
        lvl = rec[idx]; len = 1;
        while (idx + len < nrec && rec[idx + len] == lvl && len < 4) len++;
        if (len != exp_d[s] && bad_i < 0) begin bad_i = s; bad_a = len; bad_e = exp_d[s]; end
        eop = lvl; idx = idx + len;
      end
    end
    chk(bad_i < 0, "R2/R3/R4/R5 dwell sequence", bad_a, bad_e);
    // CRC levels relative to end-of-packet level (R6 R7)
    bad_i = -1;
    for (int j = 0; j < 16; j++) begin
      if (idx + j >= nrec) begin if (bad_i < 0) bad_i = j; end
      else if (rec[idx + j] != (crc[15 - j] ? eop : ~eop) && bad_i < 0) bad_i = j;
    end
    chk(bad_i < 0, "R6/R7 crc symbol levels", bad_i, -1);
    chk(irq_cnt == nb + 1, "R5/R8 host_irq pulse count", irq_cnt, nb + 1);
    chk(done_cnt == 1, "R8 crc_done pulse count", done_cnt, 1);
    req_tx = 1'b0;
    @(negedge clk);
    chk(line_out == 1'b0, "R9 line low after request cleared", int'(line_out), 0);
    rec_on = 0;
  endtask

  initial begin
    #(150000 * 20);
    fail_n++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", chk_n, fail_n);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    chk(line_out == 1'b0 && host_irq == 1'b0 && crc_done == 1'b0, "R1 outputs in reset",
        int'({line_out, host_irq, crc_done}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(line_out == 1'b0 && host_irq == 1'b0 && crc_done == 1'b0, "R1 idle outputs",
        int'({line_out, host_irq, crc_done}), 0);

    // R3 delimiter-only packet: zero byte, suppression on, end-of-packet
    pb[0] = 8'h00; pl[0] = 1'b1; pd[0] = 2'b10;
    run_packet(1);

    // near-exhaustive sweep: all byte values, both suppress settings, all delimiter codes
    for (int p = 0; p < 86; p++) begin
      for (int k = 0; k < 3; k++) begin
        pb[k] = 8'((p * 3 + k) & 255);
        pl[k] = 1'(((p >> 1) + k) & 1);
        if (k == 2) pd[k] = 2'b10;
        else begin
          case ((p + k) % 3)
            0: pd[k] = 2'b00;
            1: pd[k] = 2'b01;
            default: pd[k] = 2'b11;
          endcase
          if (pl[k] && pb[k] == 8'h00) pd[k] = 2'b01;
        end
      end
      run_packet(3);
    end

    // R9 abort in mid-byte with a second byte pending
    @(negedge clk);
    req_tx = 1'b1; tx_byte = 8'hA5; req_lzs = 1'b0; req_delim = 2'b00; byte_ready = 1'b1;
    w = 0;
    do begin @(negedge clk); w++; end while (!host_irq && w < 2000);
    tx_byte = 8'h3C; req_delim = 2'b10;
    repeat (30) @(negedge clk);
    req_tx = 1'b0; byte_ready = 1'b0;
    @(negedge clk);
    chk(line_out == 1'b0, "R9 line low one edge after abort", int'(line_out), 0);
    @(negedge clk);
    irq_cnt = 0; done_cnt = 0;
    repeat (80) @(negedge clk);
    chk(irq_cnt == 0 && done_cnt == 0, "R9 no interrupt or done after abort", irq_cnt + done_cnt, 0);
    chk(line_out == 1'b0, "R1 line low while idle after abort", int'(line_out), 0);

    // R6 fresh preset after abort
    pb[0] = 8'h5A; pl[0] = 1'b0; pd[0] = 2'b01;
    pb[1] = 8'h80; pl[1] = 1'b1; pd[1] = 2'b10;
    run_packet(2);

    chk(r10_bad == 0, "R10 line changes only on tick edges", r10_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", chk_n, fail_n);
    $finish;
  end
endmodule